// File: doc/BRIEF.md
# Bounded-Range Synchronous Up-Counter

This block is a small synchronous up-counter whose count sequence is confined to a contiguous window chosen at run time. Every storage element updates on the rising clock edge. Synchronous reset, clear and parallel load act on that same edge. Counting needs two enables: a local enable and a carry-in from the previous stage. Both must be high for the count to advance.

Two inputs bound the range. The stop value is matched by a comparator. When a stepping edge finds the count equal to the stop value, the next count is the start value instead of the next binary number. The same reload happens from the all-ones pattern, so a count loaded above the window climbs to the top and then re-enters the window at its start. A start of zero with a stop of all-ones gives a plain free-running binary counter. A stop of nine gives a decade counter.

The carry output is high when the carry-in is high and the count sits at a terminal value, which is the stop value or all-ones. To cascade stages, feed each stage's carry into the carry-in of the next, more significant stage. The upper stage then advances on exactly the edge at which the lower stage wraps.

Each edge resolves to one of six named actions, with this precedence: RESET, CLEAR, LOAD, WRAP, STEP, HOLD. The first three are taken in that order. WRAP and STEP are taken only when stepping is enabled, and WRAP is chosen when the count is terminal. HOLD applies otherwise.

Top module: `span_counter`

## Requirements
- R1: When rst_n is low at a rising edge, count_o becomes 0 after that edge, overriding every other input.
- R2: When clr_i is high (rst_n high) at a rising edge, count_o becomes 0 after that edge, overriding load and counting.
- R3: When ld_i is high (rst_n high, clr_i low) at a rising edge, count_o takes ld_data_i after that edge, with ld_data_i bit 3 as the most significant bit (4'b1000 loads eight), overriding counting.
- R4: With no reset, clear or load, count_o holds its value unless en_i and cin_i are both high at the edge.
- R5: A stepping edge (en_i and cin_i high) with count_o neither equal to stop_i nor all-ones increments count_o by one.
- R6: A stepping edge with count_o equal to stop_i loads start_i into count_o.
- R7: A stepping edge with count_o all-ones loads start_i into count_o, even when stop_i is a different value.
- R8: carry_o is combinationally high exactly when cin_i is high and count_o equals stop_i or all-ones.
- R9: Two stages cascaded, with the upper cin_i driven by the lower carry_o, count as one wider counter. The upper stage advances on the edge at which the lower stage wraps.
- R10: With start_i = 0 and stop_i = all-ones, the counter runs through every value and returns from all-ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to zero |
| ld_i | input | 1 | Synchronous parallel load |
| ld_data_i | input | WIDTH | Parallel load value, MSB first |
| en_i | input | 1 | Local count enable |
| cin_i | input | 1 | Carry-in / cascade enable, also gates carry_o |
| start_i | input | WIDTH | Value reloaded on wrap |
| stop_i | input | WIDTH | Last value of the window |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry for cascading |

## Verification
On every cycle, the assertions check the edge-by-edge rules: the precedence of reset, clear and load, holding when stepping is not enabled, the increment, the reload of the start value from the stop value and from all-ones, and the combinational definition of the carry. What only the bench scenarios can show is how these rules combine into sequences. That covers a windowed loop returning to its start, a count loaded above the window climbing to the top and re-entering, full free-running wrap, and two cascaded stages forming correct binary and decade-style wider counts.

// File: rtl/span_pkg.sv
package span_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_RESET = 3'd1,
        ACT_CLEAR = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_STEP  = 3'd4,
        ACT_WRAP  = 3'd5
    } span_act_t;

endpackage

// File: rtl/span_cmp.sv
module span_cmp #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] stop_i,
    output logic             term_o
);
    logic hit_stop;
    logic hit_top;

    always_comb begin
        hit_stop = (cur_i == stop_i);
        hit_top  = &cur_i;
        term_o   = hit_stop | hit_top;
    end

endmodule

// File: rtl/span_incr.sv
module span_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    logic [WIDTH-1:0] tgl;

    assign tgl[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 1; gi < WIDTH; gi++) begin : g_chain
            assign tgl[gi] = tgl[gi-1] & cur_i[gi-1];
        end
    endgenerate

    assign nxt_o = cur_i ^ tgl;

endmodule

// File: rtl/span_ctrl.sv
module span_ctrl
    import span_pkg::*;
(
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      ld_i,
    input  logic      en_i,
    input  logic      cin_i,
    input  logic      term_i,
    output span_act_t act_o
);
    logic [4:0] sel;

    always_comb begin
        sel = {~rst_n, clr_i, ld_i, en_i & cin_i, term_i};
        unique casez (sel)
            5'b1????: act_o = ACT_RESET;
            5'b01???: act_o = ACT_CLEAR;
            5'b001??: act_o = ACT_LOAD;
            5'b00011: act_o = ACT_WRAP;
            5'b00010: act_o = ACT_STEP;
            5'b0000?: act_o = ACT_HOLD;
            default:  act_o = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/span_counter.sv
module span_counter
    import span_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [WIDTH-1:0] ld_data_i,
    input  logic             en_i,
    input  logic             cin_i,
    input  logic [WIDTH-1:0] start_i,
    input  logic [WIDTH-1:0] stop_i,
    output logic [WIDTH-1:0] count_o,
    output logic             carry_o
);
    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_inc;
    logic             term;
    span_act_t        act;

    span_cmp #(.WIDTH(WIDTH)) u_cmp (
        .cur_i  (cnt_q),
        .stop_i (stop_i),
        .term_o (term)
    );

    span_incr #(.WIDTH(WIDTH)) u_incr (
        .cur_i (cnt_q),
        .nxt_o (cnt_inc)
    );

    span_ctrl u_ctrl (
        .rst_n  (rst_n),
        .clr_i  (clr_i),
        .ld_i   (ld_i),
        .en_i   (en_i),
        .cin_i  (cin_i),
        .term_i (term),
        .act_o  (act)
    );

    // State register: one update per edge, chosen by the decoded action.
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: cnt_q <= ZERO;
            ACT_CLEAR: cnt_q <= ZERO;
            ACT_LOAD:  cnt_q <= ld_data_i;
            ACT_WRAP:  cnt_q <= start_i;
            ACT_STEP:  cnt_q <= cnt_inc;
            ACT_HOLD:  cnt_q <= cnt_q;
            default:   cnt_q <= cnt_q;
        endcase
    end

    // Outputs.
    always_comb begin
        count_o = cnt_q;
        carry_o = cin_i & term;
    end

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> count_o == ZERO);

    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == ZERO);

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ld_i) |=> count_o == $past(ld_data_i));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && !(en_i && cin_i)) |=> $stable(count_o));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && en_i && cin_i && count_o != stop_i && !(&count_o))
        |=> count_o == $past(count_o) + ONE);

    a_r6_stop_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && en_i && cin_i && count_o == stop_i)
        |=> count_o == $past(start_i));

    a_r7_top_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !ld_i && en_i && cin_i && (&count_o))
        |=> count_o == $past(start_i));

    a_r8_carry: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |-> (cin_i && (count_o == stop_i || (&count_o))));

endmodule

// File: tb/span_counter_tb_top.sv
module span_counter_tb_top;

    localparam int W = 4;
    localparam int NV = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr, ld, en, cin;
    logic [W-1:0] ld_data, start_v, stop_v;
    logic [W-1:0] count;
    logic         carry;

    logic         hi_en;
    logic [W-1:0] hi_count;
    logic         hi_carry;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    span_counter #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .ld_i(ld), .ld_data_i(ld_data),
        .en_i(en), .cin_i(cin), .start_i(start_v), .stop_i(stop_v),
        .count_o(count), .carry_o(carry)
    );

    // Upper stage for the cascade test (R9).
    span_counter #(.WIDTH(W)) dut_hi_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .ld_i(1'b0), .ld_data_i('0),
        .en_i(hi_en), .cin_i(carry), .start_i('0), .stop_i('1),
        .count_o(hi_count), .carry_o(hi_carry)
    );

    // Vector: [23]clr [22]ld [21]en [20]cin [19:16]data [15:12]start [11:8]stop [7:4]expected [3:0]requirement
    localparam logic [23:0] VEC [NV] = '{
        {4'b0100, 4'hA, 4'h0, 4'hF, 4'hA, 4'd3},  // R3 load
        {4'b0010, 4'h0, 4'h0, 4'hF, 4'hA, 4'd4},  // R4 enable only
        {4'b0001, 4'h0, 4'h0, 4'hF, 4'hA, 4'd4},  // R4 carry-in only
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'hB, 4'd5},  // R5 step
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'hC, 4'd5},  // R5 step to stop
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'h3, 4'd6},  // R6 wrap at stop
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'h4, 4'd5},  // R5
        {4'b0111, 4'hE, 4'h3, 4'hC, 4'hE, 4'd3},  // R3 load beats count
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'hF, 4'd5},  // R5 above window
        {4'b0011, 4'h0, 4'h3, 4'hC, 4'h3, 4'd7},  // R7 wrap from top
        {4'b1111, 4'h9, 4'h3, 4'hC, 4'h0, 4'd2},  // R2 clear beats load
        {4'b0011, 4'h0, 4'h0, 4'hF, 4'h1, 4'd10}, // R10
        {4'b0100, 4'hF, 4'h0, 4'hF, 4'hF, 4'd3},  // R3
        {4'b0011, 4'h0, 4'h0, 4'hF, 4'h0, 4'd10}, // R10 full wrap
        {4'b0100, 4'h8, 4'h0, 4'hF, 4'h8, 4'd3}   // R3 bit 3 is MSB
    };

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        clr = 0; ld = 0; en = 0; cin = 0; ld_data = '0;
        start_v = '0; stop_v = '1; hi_en = 0;
        rst_n = 0;
        tick(); tick();
        chk(count == 0, "R1 reset", count, 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            logic        ec;
            v = VEC[i];
            clr = v[23]; ld = v[22]; en = v[21]; cin = v[20];
            ld_data = v[19:16]; start_v = v[15:12]; stop_v = v[11:8];
            tick();
            chk(count == v[7:4], $sformatf("R%0d vec%0d count", v[3:0], i), count, v[7:4]);
            ec = cin & ((v[7:4] == stop_v) | (v[7:4] == 4'hF));
            chk(carry == ec, $sformatf("R8 vec%0d carry", i), carry, ec);
        end

        // R8: carry at stop value gated by carry-in.
        clr = 0; en = 0; ld = 1; ld_data = 4'h6; stop_v = 4'h6; cin = 0;
        tick();
        ld = 0; #1;
        chk(carry == 0, "R8 carry needs cin", carry, 0);
        cin = 1; #1;
        chk(carry == 1, "R8 carry at stop", carry, 1);
        stop_v = 4'h9; #1;
        chk(carry == 0, "R8 no carry off stop", carry, 0);

        // R1: reset overrides load and counting.
        rst_n = 0; ld = 1; ld_data = 4'h5; en = 1; cin = 1;
        tick();
        chk(count == 0, "R1 reset priority", count, 0);
        rst_n = 1; ld = 0; en = 0;

        // R9: cascaded binary count.
        clr = 1; tick(); clr = 0;
        start_v = 0; stop_v = 4'hF; en = 1; cin = 1; hi_en = 1;
        for (int k = 1; k <= 40; k++) begin
            tick();
            chk({hi_count, count} == 8'(k), "R9 binary cascade", {hi_count, count}, k);
        end

        // R9: lower stage as decade (stop 9), upper counts tens.
        en = 0; clr = 1; tick(); clr = 0;
        stop_v = 4'h9; en = 1;
        for (int k = 1; k <= 25; k++) begin
            tick();
            chk(count == 4'(k % 10) && hi_count == 4'(k / 10), "R9 decade cascade",
                {hi_count, count}, ((k / 10) << 4) | (k % 10));
        end
        en = 0; hi_en = 0;
        tick();
        finish_run();
    end

endmodule